// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This unit keeps the interrupt status word of a single-port network controller and drives one active-high host interrupt. Receive, transmit and wake-up logic deliver single-cycle event pulses. Each pulse latches a status bit. The host reaches the status, enable, receive-queue control, power-management and frame-count registers through a synchronous register port. Writes take effect at the next clock edge. Read data is combinational from the current address.

The unit also counts the frames waiting in the receive queue. When threshold mode is on, the receive interrupt is raised only when that count climbs above a programmed threshold. Whenever the receive bit is set, the count at that moment is copied into a snapshot field. The host reads the snapshot before it clears the bit.

The four wake-up bits are not cleared by writing ones to the status word. Instead, the host writes a one-hot code into the power-management register. Every other status bit is write-one-to-clear.

Top module: `nic_irq_status`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Status bits 0 (rx overrun), 1 (tx stopped), 2 (rx stopped), 3 (tx space) and 13 (rx frames) are set by their event and cleared by writing 1 to the same position at address 0.
- R3: An event that arrives in the same cycle as a host clear of its bit wins, and the bit stays set.
- R4: Wake bits 4 (wake frame), 5 (magic packet), 6 (link up) and 7 (energy) ignore writes to address 0. They are cleared only by writing to address 3 with bits [3:0] equal to 1000 (bit 4), 0100 (bit 5), 0010 (bit 6) or 0001 (bit 7). Any other code has no effect.
- R5: Status bit 7 is set only when enable bit 7 is 1. With enable bit 15 at 0, `ev_energy` sets it. With enable bit 15 at 1, `ev_energy_late` sets it instead.
- R6: `irq` is high exactly when some status bit in 0..7 or 13 is 1 and the enable bit at the same position (address 1) is also 1.
- R7: When bit 5 of the queue control register (address 2) is 1, status bit 13 is set in the cycle the frame count goes from not above the threshold to above it.
- R8: When queue control bit 5 is 0, every received frame sets status bit 13.
- R9: Address 4 reads the snapshot in [15:8] and the read/write threshold in [7:0]. The snapshot is the frame count including the update made in the cycle that set bit 13.
- R10: The frame count rises on `frame_rcvd` and falls on `frame_freed`. When both arrive together, the count does not change. The count holds at 255 and at 0.
- R11: Unused bits and addresses read 0 and keep no written value. The enable register keeps only bits 0..7, 13 and 15. Queue control keeps only bit 5. Address 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_tx_stopped | input | 1 | Transmit process stopped pulse |
| ev_rx_stopped | input | 1 | Receive process stopped pulse |
| ev_tx_space | input | 1 | Transmit space available pulse |
| ev_wake_frame | input | 1 | Wake frame detected pulse |
| ev_magic | input | 1 | Magic packet detected pulse |
| ev_link_up | input | 1 | Link-up wake pulse |
| ev_energy | input | 1 | Energy-detect wake pulse |
| ev_energy_late | input | 1 | Delayed energy-detect wake pulse |
| frame_rcvd | input | 1 | A frame entered the receive queue |
| frame_freed | input | 1 | Host released a frame from the queue |
| irq | output | 1 | Host interrupt, active high |

## Verification
The bench uses the default CNT_W of 8 and ADDR_W of 3. With these values the 255 ceiling of the frame count is only a few hundred received frames away, so a directed run drives the count into saturation. The unused addresses 5 to 7 also exist and can be read back. A seeded random phase mixes host writes with event pulses. It checks the one-hot wake codes, same-cycle event-versus-clear collisions and threshold crossings against a cycle model in the bench.

// File: rtl/nic_irq_status.sv
module nic_irq_status #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              ev_rx_overrun,
  input  logic              ev_tx_stopped,
  input  logic              ev_rx_stopped,
  input  logic              ev_tx_space,
  input  logic              ev_wake_frame,
  input  logic              ev_magic,
  input  logic              ev_link_up,
  input  logic              ev_energy,
  input  logic              ev_energy_late,
  input  logic              frame_rcvd,
  input  logic              frame_freed,
  output logic              irq
);
  localparam logic [15:0] STAT_MASK = 16'h20FF;
  localparam logic [15:0] W1C_MASK  = 16'h200F;
  localparam logic [15:0] EN_MASK   = 16'hA0FF;
  localparam logic [15:0] CTL_MASK  = 16'h0020;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PM   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FRM  = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  CNT_TOP = '1;

  logic [15:0] stat, en, ctl, set_v, clr_v;
  logic [CNT_W-1:0] cnt, cnt_n, thr, snap;
  logic cond_q;

  wire wr_stat = host_wr && (host_addr == A_STAT);
  wire wr_en   = host_wr && (host_addr == A_EN);
  wire wr_ctl  = host_wr && (host_addr == A_CTL);
  wire wr_pm   = host_wr && (host_addr == A_PM);
  wire wr_frm  = host_wr && (host_addr == A_FRM);

  always_comb begin
    cnt_n = cnt;
    if (frame_rcvd && !frame_freed && cnt != CNT_TOP) cnt_n = cnt + 1'b1;
    else if (!frame_rcvd && frame_freed && cnt != '0) cnt_n = cnt - 1'b1;
  end

  wire cond_n = ctl[5] && (cnt_n > thr);
  wire rx_set = ctl[5] ? (cond_n && !cond_q) : frame_rcvd;
  wire nrg_set = en[7] && (en[15] ? ev_energy_late : ev_energy);
  wire [3:0] pm_code = host_wdata[3:0];

  assign set_v = {2'b00, rx_set, 5'b00000, nrg_set, ev_link_up, ev_magic, ev_wake_frame,
                  ev_tx_space, ev_rx_stopped, ev_tx_stopped, ev_rx_overrun};
  assign clr_v = (wr_stat ? (host_wdata & W1C_MASK) : 16'h0000)
               | (wr_pm ? {8'h00, pm_code == 4'b0001, pm_code == 4'b0010,
                           pm_code == 4'b0100, pm_code == 4'b1000, 4'h0} : 16'h0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat   <= '0;
      en     <= '0;
      ctl    <= '0;
      cnt    <= '0;
      thr    <= '0;
      snap   <= '0;
      cond_q <= 1'b0;
    end else begin
      stat   <= (stat & ~clr_v) | set_v;
      cnt    <= cnt_n;
      cond_q <= cond_n;
      if (wr_en)  en  <= host_wdata & EN_MASK;
      if (wr_ctl) ctl <= host_wdata & CTL_MASK;
      if (wr_frm) thr <= host_wdata[CNT_W-1:0];
      if (rx_set) snap <= cnt_n;
    end
  end

  assign irq = |(stat & en & STAT_MASK);

  always_comb begin
    case (host_addr)
      A_STAT:  host_rdata = stat;
      A_EN:    host_rdata = en;
      A_CTL:   host_rdata = ctl;
      A_FRM:   host_rdata = (16'(snap) << 8) | 16'(thr);
      default: host_rdata = 16'h0000;
    endcase
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overrun |=> stat[0]); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && host_wdata[1] && !ev_tx_stopped) |=> !stat[1]); // R2
  AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[5] && !wr_pm) |=> stat[5]); // R4
  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_TOP && frame_rcvd) |=> cnt == CNT_TOP); // R10
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && frame_freed) |=> cnt == '0); // R10
  AST_SNAP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set |=> (stat[13] && snap == cnt)); // R9
endmodule

// File: tb/nic_irq_status_test.sv
`timescale 1ns/1ps
module nic_irq_status_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] host_addr = 0;
  logic host_wr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic ev_ro = 0, ev_ts = 0, ev_rs = 0, ev_sp = 0, ev_wf = 0, ev_mg = 0, ev_lu = 0;
  logic ev_en = 0, ev_el = 0, fr = 0, ff = 0, irq;
  int total = 0, bad = 0;

  logic [15:0] m_stat = 0, m_en = 0, m_ctl = 0;
  logic [7:0] m_cnt = 0, m_thr = 0, m_snap = 0;
  logic m_cq = 0;

  always #2 clk = ~clk;

  nic_irq_status uut (.clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ev_rx_overrun(ev_ro),
    .ev_tx_stopped(ev_ts), .ev_rx_stopped(ev_rs), .ev_tx_space(ev_sp),
    .ev_wake_frame(ev_wf), .ev_magic(ev_mg), .ev_link_up(ev_lu), .ev_energy(ev_en),
    .ev_energy_late(ev_el), .frame_rcvd(fr), .frame_freed(ff), .irq(irq));

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_stat;
      3'd1: return m_en;
      3'd2: return m_ctl;
      3'd4: return {m_snap, m_thr};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(m_stat & m_en & 16'h20FF);
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    host_wr = 0; host_addr = a; #0.5;
    chk(tag, host_rdata, exp_rd(a));
  endtask

  task automatic tick();
    logic [7:0] cn;
    logic cond, rs, es;
    logic [15:0] setv, clrv;
    logic [3:0] code;
    cn = m_cnt;
    if (fr && !ff && cn != 8'hFF) cn = cn + 1;
    else if (!fr && ff && cn != 0) cn = cn - 1;
    cond = m_ctl[5] && (cn > m_thr);
    rs = m_ctl[5] ? (cond && !m_cq) : fr;
    es = m_en[7] && (m_en[15] ? ev_el : ev_en);
    setv = {2'b0, rs, 5'b0, es, ev_lu, ev_mg, ev_wf, ev_sp, ev_rs, ev_ts, ev_ro};
    clrv = 0;
    code = host_wdata[3:0];
    if (host_wr && host_addr == 0) clrv = host_wdata & 16'h200F;
    if (host_wr && host_addr == 3) begin
      if (code == 4'b1000) clrv[4] = 1;
      if (code == 4'b0100) clrv[5] = 1;
      if (code == 4'b0010) clrv[6] = 1;
      if (code == 4'b0001) clrv[7] = 1;
    end
    @(posedge clk);
    m_stat = (m_stat & ~clrv) | setv;
    if (host_wr && host_addr == 1) m_en = host_wdata & 16'hA0FF;
    if (host_wr && host_addr == 2) m_ctl = host_wdata & 16'h0020;
    if (host_wr && host_addr == 4) m_thr = host_wdata[7:0];
    if (rs) m_snap = cn;
    m_cnt = cn; m_cq = cond;
    @(negedge clk);
    host_wr = 0; ev_ro = 0; ev_ts = 0; ev_rs = 0; ev_sp = 0; ev_wf = 0; ev_mg = 0;
    ev_lu = 0; ev_en = 0; ev_el = 0; fr = 0; ff = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; tick();
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset read");
    chk("R1 irq", {15'b0, irq}, 16'h0);

    ev_ro = 1; tick(); rd(0, "R2 overrun set");
    chk("R6 irq masked", {15'b0, irq}, 16'h0);
    wr(1, 16'h0001); chk("R6 irq on", {15'b0, irq}, 16'h1);
    wr(0, 16'h0001); rd(0, "R2 w1c clear"); chk("R6 irq off", {15'b0, irq}, 16'h0);

    ev_ts = 1; tick();
    ev_ts = 1; host_wr = 1; host_addr = 0; host_wdata = 16'h0002; tick();
    rd(0, "R3 event wins");
    wr(0, 16'h0002); rd(0, "R2 tx stop cleared");

    ev_mg = 1; tick();
    wr(0, 16'h0020); rd(0, "R4 magic ignores w1c");
    wr(3, 16'h0006); rd(0, "R4 bad code ignored");
    wr(3, 16'h0004); rd(0, "R4 magic cleared");

    ev_en = 1; tick(); rd(0, "R5 energy gated off");
    wr(1, 16'h0080); ev_en = 1; tick(); rd(0, "R5 energy set");
    chk("R6 irq energy", {15'b0, irq}, 16'h1);
    wr(3, 16'h0001); rd(0, "R4 energy cleared");
    wr(1, 16'h8080); ev_en = 1; tick(); rd(0, "R5 plain ignored in late mode");
    ev_el = 1; tick(); rd(0, "R5 late sets");
    wr(3, 16'h0001);

    wr(1, 16'hFFFF); rd(1, "R11 enable mask");
    wr(2, 16'hFFFF); rd(2, "R11 ctl mask");
    wr(3, 16'hFFF0); rd(3, "R11 pm reads zero");
    wr(5, 16'hFFFF); rd(5, "R11 unused addr");
    wr(0, 16'hFFFF); rd(0, "R11 stat reserved");
    wr(2, 16'h0000); wr(1, 16'h0000);

    ff = 1; tick(); ff = 1; tick();
    fr = 1; tick(); rd(4, "R10 floor then R8 snap");
    fr = 1; ff = 1; tick(); fr = 1; tick(); rd(4, "R10 both unchanged");
    wr(0, 16'h2000);
    for (int i = 0; i < 260; i++) begin fr = 1; tick(); end
    rd(4, "R10 ceiling snap"); rd(0, "R8 rx bit");
    for (int i = 0; i < 260; i++) begin ff = 1; tick(); end
    wr(0, 16'h2000);

    wr(4, 16'h0002); wr(2, 16'h0020);
    fr = 1; tick(); fr = 1; tick(); rd(0, "R7 not above");
    fr = 1; tick(); rd(0, "R7 crossing"); rd(4, "R9 snap 3");
    wr(0, 16'h2000); fr = 1; tick(); rd(0, "R7 no recross");
    ff = 1; tick(); ff = 1; tick(); fr = 1; tick(); rd(0, "R7 recross"); rd(4, "R9 snap");

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r < 3) begin
        host_wr = 1; host_addr = 3'($urandom_range(0, 5));
        host_wdata = 16'($urandom);
        if (host_addr == 3) host_wdata = 16'(4'b1 << $urandom_range(0, 4));
      end
      ev_ro = ($urandom_range(0, 9) == 0); ev_ts = ($urandom_range(0, 9) == 0);
      ev_rs = ($urandom_range(0, 9) == 0); ev_sp = ($urandom_range(0, 9) == 0);
      ev_wf = ($urandom_range(0, 9) == 0); ev_mg = ($urandom_range(0, 9) == 0);
      ev_lu = ($urandom_range(0, 9) == 0); ev_en = ($urandom_range(0, 5) == 0);
      ev_el = ($urandom_range(0, 5) == 0);
      fr = ($urandom_range(0, 2) == 0); ff = ($urandom_range(0, 2) == 0);
      tick();
      if (i % 8 == 0) begin
        rd(0, "R2 R3 R4 R7 random stat");
        rd(4, "R9 random frame reg");
        rd(1, "R11 random enable");
        chk("R6 random irq", {15'b0, irq}, {15'b0, exp_irq()});
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule